// File: doc/BRIEF.md
# Receive Signaling Store with Debounce and Change Reporting

This block holds the robbed-bit signaling of up to 32 receive time slots of a T1 or E1 line. Each time the framer extracts a slot's ABCD nibble it presents it on a one-cycle strobe. The store then shifts it into a two-deep history for that slot. The two entries are called N (newest) and N-1. An optional per-bit debounce rule can invert the bit that ages into N-1. A frame counter raises a transfer on every 24th frame strobe. On that transfer every slot's history is copied into an output buffer, which the serial signaling path reads one bit at a time.

The output buffer value depends on how the slot is set up. In a T1 slot set for AB-only signaling with SF framing, the A and B bits of N-1 and of N are packed into one nibble, and a freeze input replaces the newer pair with the older one. In E1 AB-only slots the read path repeats A and B in the C and D positions. When a slot's new nibble differs from its previous N value and the slot's report bit is set, the slot number and the new nibble go into an eight-entry change FIFO. That FIFO has a sticky overflow flag.

Top module: `rbs_sigbuf`

## Requirements
- R1: A synchronous reset clears all histories and output buffers to 0000, empties the change FIFO, clears the overflow flag and drives rd_bit to 0.
- R2: The output buffers are loaded only on every 24th frame_stb pulse counted from reset, and the new value is readable from the cycle after that pulse. A read made after 23 pulses still returns the previous content.
- R3: With deb_en low, a sig_vld strobe sets N to sig_abcd and N-1 to the old N, bit by bit.
- R4: With deb_en high, a bit is treated as follows when its old N differs from the input and the input equals its old N-1: N takes the input and N-1 takes the inverse of the old N. Otherwise the plain shift of R3 applies. Per bit, input/N/N-1 maps to new N/N-1 as 0/00→00, 0/01→00, 0/10→00, 0/11→01, 1/00→10, 1/01→11, 1/10→11, 1/11→11.
- R5: rd_bit is registered one cycle after rd_slot/rd_phase are applied. Phases 0,1,2,3 select A,B,C,D, where A is bit 3 and D is bit 0 of the nibble.
- R6: A transfer loads a T1 (e1_mode low) sf_mode slot with ab_mode set with {A(N-1), B(N-1), A(N), B(N)}.
- R7: In that packing, while freeze is high, the C and D positions take A(N-1) and B(N-1).
- R8: In E1 mode, a slot with ab_mode set reads phases 2 and 3 as A and B, giving ABAB. Slots without ab_mode read ABCD.
- R9: A change entry is pushed only when stk_en of the slot is set and sig_abcd differs from the slot's old N. The buffers are updated regardless of stk_en.
- R10: The change FIFO holds 8 entries and returns them in arrival order on chg_slot/chg_abcd. chg_nempty is high while it holds any entry, and a chg_pop pulse removes the head.
- R11: A push into a full FIFO is dropped and sets chg_ovf, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 1 = E1 line, 0 = T1 line |
| sf_mode | input | 1 | T1 superframe framing selected |
| freeze | input | 1 | Signaling freeze |
| deb_en | input | 1 | Bit-wise debounce enable |
| ab_mode | input | 32 | Per-slot AB-only signaling |
| stk_en | input | 32 | Per-slot change reporting enable |
| frame_stb | input | 1 | One pulse per received frame |
| sig_vld | input | 1 | Extracted signaling valid |
| sig_slot | input | 5 | Slot of the extracted signaling |
| sig_abcd | input | 4 | Extracted ABCD, A in bit 3 |
| rd_slot | input | 5 | Output read slot |
| rd_phase | input | 2 | Output bit position, 0 = A |
| rd_bit | output | 1 | Registered signaling output bit |
| chg_pop | input | 1 | Remove the FIFO head |
| chg_nempty | output | 1 | Change FIFO not empty |
| chg_ovf | output | 1 | Sticky change FIFO overflow |
| chg_slot | output | 5 | Slot number at FIFO head |
| chg_abcd | output | 4 | ABCD value at FIFO head |

## Verification
The bench drives all eight debounce cases onto the A and B bits and reads both history stages back through the SF AB packing. A design that inverted the wrong stage, or that debounced on the plain-shift cases, would show the wrong N-1 there. It times the transfer by counting frames, so a counter off by one shows new data after 23 pulses or old data after 24. It checks E1 ABAB against a normal slot, freeze against unfrozen packing, and the behaviour of the FIFO when an unchanged value arrives, when reporting is off, and when a ninth entry arrives. A FIFO that overwrote the head, counted repeats as changes or cleared the overflow flag would fail those checks.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef logic [3:0] abcd_t;

  // One bit of history: returns {new N, new N-1}
  function automatic logic [1:0] deb_step(input logic x, input logic n,
                                          input logic n1, input logic deb);
    if (deb && (n != x) && (x == n1)) return {x, ~n};
    else                              return {x, n};
  endfunction
endpackage

// File: rtl/rbs_frame_ctr.sv
module rbs_frame_ctr #(
  parameter int FRAMES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  output logic xfer
);
  localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  logic [CW-1:0] cnt;

  assign xfer = frame_stb && (cnt == CW'(FRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (xfer)      cnt <= '0;
    else if (frame_stb) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rbs_slot_store.sv
module rbs_slot_store
  import rbs_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             deb_en,
  input  logic             e1_mode,
  input  logic             sf_mode,
  input  logic             freeze,
  input  logic [NSLOT-1:0] ab_mode,
  input  logic             sig_vld,
  input  logic [SW-1:0]    sig_slot,
  input  abcd_t            sig_abcd,
  input  logic             xfer,
  input  logic [SW-1:0]    rd_slot,
  output abcd_t            old_n,
  output abcd_t            rd_nib
);
  abcd_t hist_n [NSLOT];
  abcd_t hist_p [NSLOT];
  abcd_t obuf   [NSLOT];
  abcd_t upd_n, upd_p;

  assign old_n  = hist_n[sig_slot];
  assign rd_nib = obuf[rd_slot];

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      {upd_n[b], upd_p[b]} = deb_step(sig_abcd[b], hist_n[sig_slot][b],
                                      hist_p[sig_slot][b], deb_en);
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    abcd_t packed_val;
    always_comb begin
      if (ab_mode[g] && !e1_mode && sf_mode)
        packed_val = {hist_p[g][3], hist_p[g][2],
                      freeze ? hist_p[g][3] : hist_n[g][3],
                      freeze ? hist_p[g][2] : hist_n[g][2]};
      else
        packed_val = hist_n[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hist_n[g] <= '0;
        hist_p[g] <= '0;
        obuf[g]   <= '0;
      end else begin
        if (sig_vld && (sig_slot == SW'(g))) begin
          hist_n[g] <= upd_n;
          hist_p[g] <= upd_p;
        end
        if (xfer) obuf[g] <= packed_val;
      end
    end
  end

  // R3/R4: the input always becomes the newest history value
  a_r4_newest_is_input: assert property (@(posedge clk) disable iff (rst)
    sig_vld |=> hist_n[$past(sig_slot)] == $past(sig_abcd));
endmodule

// File: rtl/rbs_chg_fifo.sv
module rbs_chg_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nempty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, wr_ok, rd_ok;

  assign full   = (cnt == (AW+1)'(DEPTH));
  assign nempty = (cnt != '0);
  assign wr_ok  = push && !full;
  assign rd_ok  = pop && nempty;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
      else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
      if (push && full) ovf <= 1'b1;
    end
  end

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r10_fill_count: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !rd_ok) |=> cnt == $past(cnt) + 1'b1);
  a_r10_nempty_after_push: assert property (@(posedge clk) disable iff (rst)
    push |=> nempty);
endmodule

// File: rtl/rbs_sigbuf.sv
module rbs_sigbuf
  import rbs_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int FRAMES = 24,
  parameter int DEPTH  = 8,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             e1_mode,
  input  logic             sf_mode,
  input  logic             freeze,
  input  logic             deb_en,
  input  logic [NSLOT-1:0] ab_mode,
  input  logic [NSLOT-1:0] stk_en,
  input  logic             frame_stb,
  input  logic             sig_vld,
  input  logic [SW-1:0]    sig_slot,
  input  logic [3:0]       sig_abcd,
  input  logic [SW-1:0]    rd_slot,
  input  logic [1:0]       rd_phase,
  output logic             rd_bit,
  input  logic             chg_pop,
  output logic             chg_nempty,
  output logic             chg_ovf,
  output logic [SW-1:0]    chg_slot,
  output logic [3:0]       chg_abcd
);
  logic        xfer, chg_push;
  abcd_t       old_n, rd_nib;
  logic [1:0]  eff_phase;
  logic [SW+3:0] chg_head;

  rbs_frame_ctr #(.FRAMES(FRAMES)) u_fctr (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .xfer(xfer));

  rbs_slot_store #(.NSLOT(NSLOT), .SW(SW)) u_store (
    .clk(clk), .rst(rst), .deb_en(deb_en), .e1_mode(e1_mode),
    .sf_mode(sf_mode), .freeze(freeze), .ab_mode(ab_mode),
    .sig_vld(sig_vld), .sig_slot(sig_slot), .sig_abcd(sig_abcd),
    .xfer(xfer), .rd_slot(rd_slot), .old_n(old_n), .rd_nib(rd_nib));

  assign chg_push = sig_vld && stk_en[sig_slot] && (sig_abcd != old_n);

  rbs_chg_fifo #(.DEPTH(DEPTH), .W(SW + 4)) u_fifo (
    .clk(clk), .rst(rst), .push(chg_push), .din({sig_slot, sig_abcd}),
    .pop(chg_pop), .head(chg_head), .nempty(chg_nempty), .ovf(chg_ovf));

  assign chg_slot = chg_head[SW+3:4];
  assign chg_abcd = chg_head[3:0];

  // E1 AB-only: C and D positions repeat A and B
  assign eff_phase = (e1_mode && ab_mode[rd_slot]) ? {1'b0, rd_phase[0]} : rd_phase;

  always_ff @(posedge clk) begin
    if (rst) rd_bit <= 1'b0;
    else     rd_bit <= rd_nib[2'd3 - eff_phase];
  end

  a_r2_xfer_spacing: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);
endmodule

// File: tb/rbs_sigbuf_tb.sv
module rbs_sigbuf_tb;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst = 1, e1_mode = 0, sf_mode = 1, freeze = 0, deb_en = 0;
  logic [31:0] ab_mode = '0, stk_en = '0;
  logic frame_stb = 0, sig_vld = 0, chg_pop = 0;
  logic [4:0] sig_slot = '0, rd_slot = '0;
  logic [3:0] sig_abcd = '0;
  logic [1:0] rd_phase = '0;
  logic rd_bit, chg_nempty, chg_ovf;
  logic [4:0] chg_slot;
  logic [3:0] chg_abcd;

  int checks = 0, errors = 0, fcnt = 0;

  rbs_sigbuf u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    @(negedge clk); @(negedge clk) rst = 0;
    fcnt = 0;
  endtask

  task automatic push(input int s, input int v);
    @(negedge clk) begin sig_vld = 1; sig_slot = 5'(s); sig_abcd = 4'(v); end
    @(negedge clk) sig_vld = 0;
  endtask

  task automatic frame();
    @(negedge clk) frame_stb = 1;
    @(negedge clk) frame_stb = 0;
    fcnt = (fcnt + 1) % 24;
  endtask

  task automatic xfer_now();
    frame();
    while (fcnt != 0) frame();
  endtask

  task automatic read_nib(input int s, output logic [3:0] v);
    for (int ph = 0; ph < 4; ph++) begin
      @(negedge clk) begin rd_slot = 5'(s); rd_phase = 2'(ph); end
      @(negedge clk) v[3-ph] = rd_bit;
    end
  endtask

  task automatic pop();
    @(negedge clk) chg_pop = 1;
    @(negedge clk) chg_pop = 0;
  endtask

  // R4 table, index {input, N, N-1} -> {new N, new N-1}
  function automatic logic [1:0] deb_ref(input int idx);
    case (idx)
      0: return 2'b00; 1: return 2'b00; 2: return 2'b00; 3: return 2'b01;
      4: return 2'b10; 5: return 2'b11; 6: return 2'b11; default: return 2'b11;
    endcase
  endfunction

  task automatic t_reset();
    logic [3:0] v;
    chk("R1 rd_bit", rd_bit, 0);
    chk("R1 nempty", chg_nempty, 0);
    chk("R1 ovf", chg_ovf, 0);
    read_nib(5, v);
    chk("R1 buffer", v, 0);
  endtask

  task automatic t_timing();
    logic [3:0] v;
    xfer_now();
    push(3, 4'b1010);
    repeat (23) frame();
    read_nib(3, v);
    chk("R2 before 24th", v, 4'b0000);
    frame();
    read_nib(3, v);
    chk("R2 after 24th", v, 4'b1010);
  endtask

  task automatic t_debounce();
    logic [3:0] v;
    logic [1:0] ea, eb;
    ab_mode[10] = 1; e1_mode = 0; sf_mode = 1; freeze = 0;
    for (int k = 0; k < 8; k++) begin
      int ka, kb;
      ka = k; kb = 7 - k;
      deb_en = 0;
      push(10, {ka[0], kb[0], 2'b00});           // becomes N-1
      push(10, {ka[1], kb[1], 2'b00});           // becomes N
      deb_en = 1;
      push(10, {ka[2], kb[2], 2'b00});           // input
      deb_en = 0;
      xfer_now();
      read_nib(10, v);
      ea = deb_ref(ka); eb = deb_ref(kb);
      chk($sformatf("R4 case A%0d B%0d", ka, kb), v, {ea[0], eb[0], ea[1], eb[1]});
    end
  endtask

  task automatic t_plain_and_freeze();
    logic [3:0] v;
    deb_en = 0;
    // A: in 0, N 1, N-1 0 ; B: in 1, N 0, N-1 1
    push(10, 4'b0100);
    push(10, 4'b1000);
    push(10, 4'b0100);
    xfer_now();
    read_nib(10, v);
    chk("R3/R6 plain shift packing", v, 4'b1001);
    freeze = 1;
    xfer_now();
    read_nib(10, v);
    chk("R7 freeze", v, 4'b1010);
    freeze = 0;
  endtask

  task automatic t_normal_e1();
    logic [3:0] v;
    push(12, 4'b0110);
    xfer_now();
    read_nib(12, v);
    chk("R5 ABCD order", v, 4'b0110);
    e1_mode = 1; ab_mode[13] = 1;
    push(13, 4'b1001);
    push(14, 4'b1001);
    xfer_now();
    read_nib(13, v);
    chk("R8 ABAB", v, 4'b1010);
    read_nib(14, v);
    chk("R8 ABCD slot", v, 4'b1001);
    e1_mode = 0;
  endtask

  task automatic t_fifo();
    logic [3:0] v;
    do_reset();
    stk_en = '0; stk_en[7] = 1;
    push(7, 4'b0101);
    chk("R9 push on change", chg_nempty, 1);
    chk("R10 head slot", chg_slot, 7);
    chk("R10 head value", chg_abcd, 4'b0101);
    pop();
    chk("R10 empty after pop", chg_nempty, 0);
    push(7, 4'b0101);
    chk("R9 no push when unchanged", chg_nempty, 0);
    push(8, 4'b0011);
    chk("R9 no push when disabled", chg_nempty, 0);
    xfer_now();
    read_nib(8, v);
    chk("R9 buffer updated when disabled", v, 4'b0011);
    for (int k = 0; k < 9; k++) push(7, 6 + k);
    chk("R11 ovf set", chg_ovf, 1);
    for (int k = 0; k < 8; k++) begin
      chk("R10 order nempty", chg_nempty, 1);
      chk("R10 order slot", chg_slot, 7);
      chk($sformatf("R10 order value %0d", k), chg_abcd, 6 + k);
      pop();
    end
    chk("R11 ninth dropped", chg_nempty, 0);
    chk("R11 ovf sticky", chg_ovf, 1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_timing();
    t_debounce();
    t_plain_and_freeze();
    t_normal_e1();
    t_fifo();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule